// File: doc/BRIEF.md
# Event-Based Branch Exception Controller

This block turns a performance-monitor alert into a user-level branch. An alert counts only when monitor branching is enabled, event posting is enabled and the global branch enable is set. It must also pass two facility checks, one at supervisor level and one at hypervisor level. An alert that passes becomes a latched pending request. An alert that is armed but blocked by a facility check raises a facility-unavailable fault instead.

A pending request is checked a second time before it is delivered. It is taken only in user state, only while the global enable is set, and only when no return-from-branch is executing in the same cycle. A request that fails this check stays latched. It never jumps to a handler address that has not been set up yet.

Delivery saves the next-instruction address in a return register, clears the global enable, sets the event-occurred flag and sends fetch to the handler register. A return-from-branch instruction sends fetch back to the saved address. Its operand either re-arms the global enable or leaves it clear. Software loads the handler, return and status registers through a single write port.

Top module: `evbr_ctrl`

## Requirements
- R1: An alert sets the pending request only when `mon_branch_en`, status PME and status GE are all 1 and both facility enables are 1. Any other alert leaves pending unchanged.
- R2: An alert with `mon_branch_en`, PME and GE all set but a facility enable clear does not set pending. On the next cycle it pulses `fault_valid` with `fault_cause` = 7. `fault_hyp` is 0 when the supervisor enable is clear and 1 when only the hypervisor enable is clear.
- R3: A pending request is delivered only while `user_mode`=1 and GE=1. Otherwise it stays pending for any number of cycles.
- R4: Delivery clears pending and GE and sets PMEO, all visible on the cycle after the decision.
- R5: Delivery loads `cur_nia` into the return register and drives `redirect_addr` with the handler register value it had before the edge.
- R6: `rfe_valid` drives `redirect_valid` on the next cycle, with `redirect_addr` equal to the return register.
- R7: `rfe_valid` with `rfe_arm`=0 leaves GE at 0. With `rfe_arm`=1 it sets GE, so a pending request in user state is delivered on the following cycle.
- R8: When a software status write and a delivery update GE or PMEO in the same cycle, the delivery wins. A delivery also wins over a software write to the return register.
- R9: `redirect_valid` is high for exactly one cycle per redirect. If a delivery and a return-from-branch compete, the return goes first and the request stays pending.
- R10: Software write port: `sw_sel` 0 selects the handler, 1 the return register, 2 status. The status bits are [0] GE, [1] PME, [2] PMEO.
- R11: Reset clears pending, all status bits, both address registers, `redirect_valid` and `fault_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_alert | input | 1 | Performance monitor alert strobe |
| mon_branch_en | input | 1 | Branch-on-alert enable from the monitor control register |
| fac_sup_en | input | 1 | Supervisor facility enable for branching |
| fac_hyp_en | input | 1 | Hypervisor facility enable for branching |
| user_mode | input | 1 | Processor is in problem (user) state |
| cur_nia | input | AW | Current next-instruction address |
| rfe_valid | input | 1 | Return-from-branch instruction executes |
| rfe_arm | input | 1 | Return-from-branch operand (1 sets GE) |
| sw_we | input | 1 | Software register write strobe |
| sw_sel | input | 2 | Software write target |
| sw_wdata | input | AW | Software write data |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_addr | output | AW | Fetch redirect target |
| handler_addr | output | AW | Handler register |
| return_addr | output | AW | Return register |
| status_ge | output | 1 | Global enable |
| status_pme | output | 1 | Event posting enable |
| status_pmeo | output | 1 | Event occurred flag |
| pending | output | 1 | Latched branch request |
| fault_valid | output | 1 | Facility-unavailable fault strobe |
| fault_hyp | output | 1 | Fault raised at hypervisor level |
| fault_cause | output | 8 | Fault cause code |

## Verification
The bench first holds a request pending outside user state. It then clears GE while the request is still latched, which models the lost-event race. A controller without the second gate would jump to the handler straight away, and one that dropped the request would never deliver it after the re-arming return. A return-from-branch is also issued in the same cycle as a ready delivery. A design with the wrong priority would redirect to the handler or lose the pending flag. A software status write that lands on a delivery checks that GE ends cleared and PMEO set. The two facility cases check that the fault level is reported correctly and that no request is latched.

// File: rtl/evbr_pkg.sv
package evbr_pkg;

    typedef enum logic [1:0] {
        SEL_HANDLER = 2'd0,
        SEL_RETURN  = 2'd1,
        SEL_STATUS  = 2'd2,
        SEL_NONE    = 2'd3
    } sw_sel_e;

    typedef struct packed {
        logic pmeo;
        logic pme;
        logic ge;
    } stat_t;

    typedef struct packed {
        logic clr_ge;
        logic set_ge;
        logic set_pmeo;
        logic load_ret;
    } hw_upd_t;

    function automatic stat_t stat_from_bits(input logic [2:0] b);
        stat_t s;
        s.ge   = b[0];
        s.pme  = b[1];
        s.pmeo = b[2];
        return s;
    endfunction

endpackage

// File: rtl/evbr_qualify.sv
module evbr_qualify #(
    parameter int CW        = 8,
    parameter int FAC_CAUSE = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pm_alert,
    input  logic          mon_branch_en,
    input  logic          stat_pme,
    input  logic          stat_ge,
    input  logic          fac_sup_en,
    input  logic          fac_hyp_en,
    input  logic          take,
    output logic          pending,
    output logic          fault_valid,
    output logic          fault_hyp,
    output logic [CW-1:0] fault_cause
);
    localparam logic [CW-1:0] CAUSE_CODE = CW'(FAC_CAUSE);

    logic armed, fac_ok, raise, fault;

    always_comb begin
        armed  = pm_alert & mon_branch_en & stat_pme & stat_ge;
        fac_ok = fac_sup_en & fac_hyp_en;
        raise  = armed & fac_ok;
        fault  = armed & ~fac_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending     <= 1'b0;
            fault_valid <= 1'b0;
            fault_hyp   <= 1'b0;
            fault_cause <= '0;
        end else begin
            pending     <= raise | (pending & ~take);
            fault_valid <= fault;
            fault_hyp   <= fault & fac_sup_en;
            fault_cause <= fault ? CAUSE_CODE : '0;
        end
    end
endmodule

// File: rtl/evbr_deliver.sv
module evbr_deliver
    import evbr_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pending,
    input  logic          user_mode,
    input  logic          stat_ge,
    input  logic          rfe_valid,
    input  logic          rfe_arm,
    input  logic [AW-1:0] handler_addr,
    input  logic [AW-1:0] return_addr,
    output logic          take,
    output hw_upd_t       hw_upd,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_addr
);
    always_comb begin
        take            = pending & user_mode & stat_ge & ~rfe_valid;
        hw_upd.clr_ge   = take | (rfe_valid & ~rfe_arm);
        hw_upd.set_ge   = rfe_valid & rfe_arm;
        hw_upd.set_pmeo = take;
        hw_upd.load_ret = take;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            redirect_valid <= 1'b0;
            redirect_addr  <= '0;
        end else begin
            redirect_valid <= take | rfe_valid;
            if (rfe_valid)
                redirect_addr <= return_addr;
            else if (take)
                redirect_addr <= handler_addr;
        end
    end
endmodule

// File: rtl/evbr_regs.sv
module evbr_regs
    import evbr_pkg::*;
#(
    parameter int AW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sw_we,
    input  logic [1:0]    sw_sel,
    input  logic [AW-1:0] sw_wdata,
    input  hw_upd_t       hw_upd,
    input  logic [AW-1:0] cur_nia,
    output stat_t         stat,
    output logic [AW-1:0] handler_addr,
    output logic [AW-1:0] return_addr
);
    stat_t stat_n;
    logic  wr_stat, wr_hand, wr_ret;

    always_comb begin
        wr_hand = sw_we && (sw_sel_e'(sw_sel) == SEL_HANDLER);
        wr_ret  = sw_we && (sw_sel_e'(sw_sel) == SEL_RETURN);
        wr_stat = sw_we && (sw_sel_e'(sw_sel) == SEL_STATUS);
        stat_n  = wr_stat ? stat_from_bits(sw_wdata[2:0]) : stat;
        if (hw_upd.clr_ge)   stat_n.ge   = 1'b0;
        if (hw_upd.set_ge)   stat_n.ge   = 1'b1;
        if (hw_upd.set_pmeo) stat_n.pmeo = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat         <= '0;
            handler_addr <= '0;
            return_addr  <= '0;
        end else begin
            stat <= stat_n;
            if (wr_hand)
                handler_addr <= sw_wdata;
            if (hw_upd.load_ret)
                return_addr <= cur_nia;
            else if (wr_ret)
                return_addr <= sw_wdata;
        end
    end
endmodule

// File: rtl/evbr_ctrl.sv
module evbr_ctrl
    import evbr_pkg::*;
#(
    parameter int AW        = 64,
    parameter int CW        = 8,
    parameter int FAC_CAUSE = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pm_alert,
    input  logic          mon_branch_en,
    input  logic          fac_sup_en,
    input  logic          fac_hyp_en,
    input  logic          user_mode,
    input  logic [AW-1:0] cur_nia,
    input  logic          rfe_valid,
    input  logic          rfe_arm,
    input  logic          sw_we,
    input  logic [1:0]    sw_sel,
    input  logic [AW-1:0] sw_wdata,
    output logic          redirect_valid,
    output logic [AW-1:0] redirect_addr,
    output logic [AW-1:0] handler_addr,
    output logic [AW-1:0] return_addr,
    output logic          status_ge,
    output logic          status_pme,
    output logic          status_pmeo,
    output logic          pending,
    output logic          fault_valid,
    output logic          fault_hyp,
    output logic [CW-1:0] fault_cause
);
    stat_t   stat;
    hw_upd_t hw_upd;
    logic    take;

    assign status_ge   = stat.ge;
    assign status_pme  = stat.pme;
    assign status_pmeo = stat.pmeo;

    evbr_qualify #(.CW(CW), .FAC_CAUSE(FAC_CAUSE)) u_qual (
        .clk(clk), .rst(rst), .pm_alert(pm_alert), .mon_branch_en(mon_branch_en),
        .stat_pme(stat.pme), .stat_ge(stat.ge), .fac_sup_en(fac_sup_en),
        .fac_hyp_en(fac_hyp_en), .take(take), .pending(pending),
        .fault_valid(fault_valid), .fault_hyp(fault_hyp), .fault_cause(fault_cause)
    );

    evbr_deliver #(.AW(AW)) u_dlv (
        .clk(clk), .rst(rst), .pending(pending), .user_mode(user_mode),
        .stat_ge(stat.ge), .rfe_valid(rfe_valid), .rfe_arm(rfe_arm),
        .handler_addr(handler_addr), .return_addr(return_addr), .take(take),
        .hw_upd(hw_upd), .redirect_valid(redirect_valid), .redirect_addr(redirect_addr)
    );

    evbr_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst(rst), .sw_we(sw_we), .sw_sel(sw_sel), .sw_wdata(sw_wdata),
        .hw_upd(hw_upd), .cur_nia(cur_nia), .stat(stat),
        .handler_addr(handler_addr), .return_addr(return_addr)
    );
endmodule

// File: rtl/evbr_ctrl_chk.sv
module evbr_ctrl_chk #(
    parameter int AW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          pm_alert,
    input logic          mon_branch_en,
    input logic          fac_sup_en,
    input logic          fac_hyp_en,
    input logic          user_mode,
    input logic [AW-1:0] cur_nia,
    input logic          rfe_valid,
    input logic          rfe_arm,
    input logic          redirect_valid,
    input logic [AW-1:0] redirect_addr,
    input logic [AW-1:0] handler_addr,
    input logic [AW-1:0] return_addr,
    input logic          status_ge,
    input logic          status_pme,
    input logic          status_pmeo,
    input logic          pending,
    input logic          fault_valid
);
    logic ready;
    assign ready = pending && user_mode && status_ge && !rfe_valid;

    AST_NO_RAISE_UNARMED: assert property (@(posedge clk) disable iff (rst)
        (!pending && !(pm_alert && mon_branch_en && status_pme && status_ge)) |=> !pending); // R1

    AST_FAULT_ON_FACILITY: assert property (@(posedge clk) disable iff (rst)
        (pm_alert && mon_branch_en && status_pme && status_ge && !(fac_sup_en && fac_hyp_en))
        |=> fault_valid); // R2

    AST_HOLD_PENDING: assert property (@(posedge clk) disable iff (rst)
        (pending && !ready) |=> pending); // R3

    AST_TAKE_STATUS: assert property (@(posedge clk) disable iff (rst)
        ready |=> (redirect_valid && !status_ge && status_pmeo)); // R4

    AST_TAKE_ADDRS: assert property (@(posedge clk) disable iff (rst)
        ready |=> (return_addr == $past(cur_nia) && redirect_addr == $past(handler_addr))); // R5

    AST_RFE_TARGET: assert property (@(posedge clk) disable iff (rst)
        rfe_valid |=> (redirect_valid && redirect_addr == $past(return_addr))); // R6

    AST_RFE_GE: assert property (@(posedge clk) disable iff (rst)
        rfe_valid |=> (status_ge == $past(rfe_arm))); // R7

    AST_NO_SPURIOUS_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (!pending && !rfe_valid) |=> !redirect_valid); // R9
endmodule

bind evbr_ctrl evbr_ctrl_chk #(.AW(AW)) u_chk (.*);

// File: tb/evbr_ctrl_test.sv
module evbr_ctrl_test;
    localparam int AW = 64;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          pm_alert = 0, mon_branch_en = 0, fac_sup_en = 0, fac_hyp_en = 0;
    logic          user_mode = 0, rfe_valid = 0, rfe_arm = 0, sw_we = 0;
    logic [1:0]    sw_sel = 2'd3;
    logic [AW-1:0] cur_nia = '0, sw_wdata = '0;
    logic          redirect_valid, status_ge, status_pme, status_pmeo, pending;
    logic          fault_valid, fault_hyp;
    logic [AW-1:0] redirect_addr, handler_addr, return_addr;
    logic [7:0]    fault_cause;

    int tests = 0, fails = 0;
    logic [AW-1:0] expq[$];

    always #5 clk = ~clk;

    evbr_ctrl uut (
        .clk(clk), .rst(rst), .pm_alert(pm_alert), .mon_branch_en(mon_branch_en),
        .fac_sup_en(fac_sup_en), .fac_hyp_en(fac_hyp_en), .user_mode(user_mode),
        .cur_nia(cur_nia), .rfe_valid(rfe_valid), .rfe_arm(rfe_arm), .sw_we(sw_we),
        .sw_sel(sw_sel), .sw_wdata(sw_wdata), .redirect_valid(redirect_valid),
        .redirect_addr(redirect_addr), .handler_addr(handler_addr),
        .return_addr(return_addr), .status_ge(status_ge), .status_pme(status_pme),
        .status_pmeo(status_pmeo), .pending(pending), .fault_valid(fault_valid),
        .fault_hyp(fault_hyp), .fault_cause(fault_cause)
    );

    task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] sel, input logic [AW-1:0] d);
        sw_we = 1; sw_sel = sel; sw_wdata = d;
        nxt();
        sw_we = 0; sw_sel = 2'd3;
    endtask

    task automatic alert();
        pm_alert = 1;
        nxt();
        pm_alert = 0;
    endtask

    // monitor: pops expected redirect targets (R5, R6, R9)
    always @(negedge clk) begin
        if (!rst && redirect_valid) begin
            tests++;
            if (expq.size() == 0) begin
                fails++;
                $display("FAIL R9: unexpected redirect actual %0h expected none", redirect_addr);
            end else begin
                logic [AW-1:0] e;
                e = expq.pop_front();
                if (redirect_addr !== e) begin
                    fails++;
                    $display("FAIL R5/R6 redirect: actual %0h expected %0h", redirect_addr, e);
                end
            end
        end
    end

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        nxt(); nxt(); nxt();
        rst = 0;
        check("R11 pending", pending, 0);
        check("R11 redirect", redirect_valid, 0);
        check("R11 status", {status_pmeo, status_pme, status_ge}, 0);
        check("R11 fault", fault_valid, 0);
        check("R11 handler", handler_addr, 0);

        mon_branch_en = 1; fac_sup_en = 1; fac_hyp_en = 1; user_mode = 1;
        cur_nia = 64'h2000;
        wr(2'd0, 64'h1000);
        check("R10 handler write", handler_addr, 64'h1000);
        wr(2'd2, 64'h3);
        check("R10 status write", {status_pmeo, status_pme, status_ge}, 3'b011);

        // basic delivery
        alert();
        check("R1 pending set", pending, 1);
        expq.push_back(64'h1000);
        nxt();
        check("R5 return saved", return_addr, 64'h2000);
        check("R4 ge cleared", status_ge, 0);
        check("R4 pmeo set", status_pmeo, 1);
        check("R4 pending cleared", pending, 0);
        nxt();
        check("R9 single pulse", redirect_valid, 0);

        // alert with GE clear, and with monitor enable clear
        alert();
        check("R1 ge clear ignored", pending, 0);
        check("R1 no fault", fault_valid, 0);
        wr(2'd2, 64'h3);
        mon_branch_en = 0;
        alert();
        check("R1 monitor disable ignored", pending, 0);
        mon_branch_en = 1;

        // return with operand 0
        expq.push_back(64'h2000);
        rfe_valid = 1; rfe_arm = 0;
        nxt();
        rfe_valid = 0;
        check("R7 rfe 0 clears ge", status_ge, 0);

        // held pending, lost-event race, re-arm
        wr(2'd2, 64'h3);
        user_mode = 0; cur_nia = 64'h3000;
        alert();
        check("R3 pending latched", pending, 1);
        nxt(); nxt(); nxt();
        check("R3 held outside user", pending, 1);
        wr(2'd2, 64'h2);
        user_mode = 1;
        nxt(); nxt();
        check("R3 held with ge clear", pending, 1);
        expq.push_back(64'h2000);
        expq.push_back(64'h1000);
        rfe_valid = 1; rfe_arm = 1;
        nxt();
        rfe_valid = 0;
        check("R7 rfe 1 sets ge", status_ge, 1);
        nxt();
        check("R7 delivered after rearm", pending, 0);
        check("R5 return updated", return_addr, 64'h3000);

        // return beats delivery in the same cycle
        wr(2'd2, 64'h3);
        user_mode = 0;
        alert();
        user_mode = 1; rfe_valid = 1; rfe_arm = 0;
        expq.push_back(64'h3000);
        nxt();
        rfe_valid = 0;
        check("R9 pending kept", pending, 1);
        check("R9 ge from rfe", status_ge, 0);
        nxt(); nxt();
        check("R9 no extra redirect", expq.size(), 0);

        // hardware beats software status write
        user_mode = 0;
        wr(2'd2, 64'h3);
        user_mode = 1;
        sw_we = 1; sw_sel = 2'd2; sw_wdata = 64'h1;
        expq.push_back(64'h1000);
        nxt();
        sw_we = 0; sw_sel = 2'd3;
        check("R8 ge cleared by hw", status_ge, 0);
        check("R8 pmeo set by hw", status_pmeo, 1);
        check("R8 pme from sw", status_pme, 0);

        // facility faults
        wr(2'd2, 64'h3);
        fac_sup_en = 0;
        alert();
        check("R2 fault sup", fault_valid, 1);
        check("R2 fault level sup", fault_hyp, 0);
        check("R2 cause", fault_cause, 7);
        check("R2 no pending", pending, 0);
        nxt();
        check("R2 fault pulse", fault_valid, 0);
        fac_sup_en = 1; fac_hyp_en = 0;
        alert();
        check("R2 fault hyp", fault_valid, 1);
        check("R2 fault level hyp", fault_hyp, 1);
        fac_hyp_en = 1;

        nxt(); nxt(); nxt();
        check("R9 queue drained", expq.size(), 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule